// File: doc/BRIEF.md
# NAND Chunk ECC Syndrome Checker

This block takes the parity code freshly computed over a 256-byte chunk of NAND data and the code that was read back from the spare area. It compares the two and sorts the result into one of four classes. The chunk can be clean. The code itself can have taken a hit. A single data bit can have flipped, in which case the block also gives its location. Any other difference is reported as damage that cannot be repaired. Each code is 22 bits wide and is carried as three bytes, with the first byte in bits 7:0. Bits 10:0 hold the line/column parities and bits 21:11 hold their complements.

Codes enter through a valid/ready handshake, one pair per accepted transfer. The verdict is registered and appears on the cycle after the handshake. A side port fixes one data byte at a time. The caller presents a byte and its index within the chunk. If the registered verdict is a correctable error and the index matches the failing byte, the byte comes back with the failing bit inverted. For a 512-byte page, the caller asserts the wide-page input and sends the two chunk codes one after the other. The block tags each verdict with the chunk it belongs to.

Top module: `ecc_chunk_check`

## Requirements
- R1: While reset is asserted, `out_valid` and `in_ready` are 0. From the first clock edge after reset is released, `in_ready` is 1.
- R2: The status is clean (0) when the 24-bit syndrome (calc XOR stored) is zero, or when either 24-bit code is all zeros.
- R3: When the syndrome has exactly one bit set (and R2 does not apply), the status is code-corrupt (2). The fix-up port then returns every byte unchanged.
- R4: The status is corrected (1) when all of the following hold:
  - the syndrome has exactly 11 bits set;
  - (calc[10:0]^calc[21:11])^(stored[10:0]^stored[21:11]) equals 0x7FF.
  
  In that case `fail_bit` = syndrome[2:0] and `fail_byte` = syndrome[10:3].
- R5: Every other nonzero syndrome gives status uncorrectable (3). This includes 11 set bits where a parity pair is not split.
- R6: `out_valid` is high for exactly the one cycle after each accepted handshake. The status, chunk and location outputs hold their values until the next accepted handshake.
- R7: When the status is corrected (1) and `fix_idx` equals `fail_byte`, `fix_byte_out` = `fix_byte_in` XOR (1 << `fail_bit`). In every other case it equals `fix_byte_in`.
- R8: With `wide_page` = 1, successive verdicts carry `out_chunk` 0, 1, 0, 1, … Each chunk is classified on its own codes only. A handshake with `wide_page` = 0 gives `out_chunk` 0 and restarts the alternation, so the next wide-page handshake is chunk 0.
- R9: `fail_byte` and `fail_bit` are zero whenever the status is not corrected (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A code pair is offered |
| in_ready | output | 1 | The block accepts a code pair |
| wide_page | input | 1 | The code pair belongs to a two-chunk (512-byte) page |
| calc_code | input | 24 | Code computed from the data, first byte in bits 7:0 |
| stored_code | input | 24 | Code read from the spare area, same layout |
| out_valid | output | 1 | One-cycle pulse marking a new verdict |
| out_status | output | 2 | 0 clean, 1 corrected, 2 code corrupt, 3 uncorrectable |
| out_chunk | output | 1 | Chunk number within a wide page |
| fail_byte | output | 8 | Index of the failing byte in the chunk |
| fail_bit | output | 3 | Position of the failing bit in that byte |
| fix_idx | input | 8 | Index of the byte presented for fix-up |
| fix_byte_in | input | 8 | Data byte presented for fix-up |
| fix_byte_out | output | 8 | Data byte after fix-up |

## Verification
Random code pairs almost never produce a correctable pattern. That pattern needs eleven differing bits with every parity pair split, so random stimulus alone rarely reaches it. The stimulus therefore builds such pairs on purpose. It picks a byte index and a bit position. It forms the syndrome with the location in the low half and its complement in the high half, then XORs that syndrome onto a random stored code. Directed pairs cover the ends of the location range (byte 0 bit 0, and byte 255 bit 7). They also cover an eleven-bit syndrome with one unsplit pair, which must not be taken as correctable.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
    localparam int HALF_W  = 11;
    localparam int BIT_W   = 3;
    localparam int BYTE_W  = HALF_W - BIT_W;
    localparam int CODE_W  = 24;
    localparam int ONES_W  = $clog2(CODE_W + 1);

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXED    = 2'd1,
        ST_CODE_BAD = 2'd2,
        ST_FATAL    = 2'd3
    } ecc_status_e;

    typedef struct packed {
        ecc_status_e         status;
        logic [BYTE_W-1:0]   byte_idx;
        logic [BIT_W-1:0]    bit_pos;
    } ecc_verdict_t;
endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
    parameter int W   = 24,
    parameter int O_W = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec,
    output logic [O_W-1:0] ones
);
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + O_W'(vec[i]);
        end
    end
endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
    import ecc_chk_pkg::*;
(
    input  logic [CODE_W-1:0] calc,
    input  logic [CODE_W-1:0] stored,
    output ecc_verdict_t      verdict
);
    logic [CODE_W-1:0] syn;
    logic [ONES_W-1:0] syn_ones;
    logic [HALF_W-1:0] calc_fold;
    logic [HALF_W-1:0] stored_fold;
    logic [HALF_W-1:0] pair_mix;

    assign syn = calc ^ stored;

    ecc_popcount #(.W(CODE_W), .O_W(ONES_W)) u_count (
        .vec  (syn),
        .ones (syn_ones)
    );

    always_comb begin
        calc_fold   = calc[HALF_W-1:0] ^ calc[2*HALF_W-1:HALF_W];
        stored_fold = stored[HALF_W-1:0] ^ stored[2*HALF_W-1:HALF_W];
        pair_mix    = calc_fold ^ stored_fold;

        verdict = '{status: ST_CLEAN, byte_idx: '0, bit_pos: '0};
        if (syn == '0 || calc == '0 || stored == '0) begin
            verdict.status = ST_CLEAN;
        end else if (syn_ones == ONES_W'(1)) begin
            verdict.status = ST_CODE_BAD;
        end else if (syn_ones == ONES_W'(HALF_W) && pair_mix == '1) begin
            verdict.status   = ST_FIXED;
            verdict.bit_pos  = syn[BIT_W-1:0];
            verdict.byte_idx = syn[HALF_W-1:BIT_W];
        end else begin
            verdict.status = ST_FATAL;
        end
    end
endmodule

// File: rtl/ecc_byte_fixup.sv
module ecc_byte_fixup
    import ecc_chk_pkg::*;
(
    input  ecc_verdict_t      verdict,
    input  logic [BYTE_W-1:0] idx,
    input  logic [7:0]        byte_in,
    output logic [7:0]        byte_out
);
    logic [7:0] flip_mask;
    logic       hit;

    assign hit = (verdict.status == ST_FIXED) && (idx == verdict.byte_idx);

    for (genvar b = 0; b < 8; b++) begin : g_mask
        assign flip_mask[b] = hit && (verdict.bit_pos == BIT_W'(b));
    end

    assign byte_out = byte_in ^ flip_mask;
endmodule

// File: rtl/ecc_chunk_check.sv
module ecc_chunk_check
    import ecc_chk_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  wide_page,
    input  logic [CODE_W-1:0]     calc_code,
    input  logic [CODE_W-1:0]     stored_code,
    output logic                  out_valid,
    output logic [1:0]            out_status,
    output logic                  out_chunk,
    output logic [BYTE_W-1:0]     fail_byte,
    output logic [BIT_W-1:0]      fail_bit,
    input  logic [BYTE_W-1:0]     fix_idx,
    input  logic [7:0]            fix_byte_in,
    output logic [7:0]            fix_byte_out
);
    typedef struct packed {
        logic         ready;
        logic         pulse;
        logic         next_chunk;
        logic         chunk;
        ecc_verdict_t verdict;
    } ctl_t;

    ctl_t         ctl_d, ctl_q;
    ecc_verdict_t verdict_now;
    logic         accept;

    assign accept = in_valid && ctl_q.ready;

    ecc_syndrome_classify u_cls (
        .calc    (calc_code),
        .stored  (stored_code),
        .verdict (verdict_now)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.ready = 1'b1;
        ctl_d.pulse = accept;
        if (accept) begin
            ctl_d.verdict    = verdict_now;
            ctl_d.chunk      = wide_page ? ctl_q.next_chunk : 1'b0;
            ctl_d.next_chunk = wide_page ? ~ctl_q.next_chunk : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ready: 1'b0, pulse: 1'b0, next_chunk: 1'b0, chunk: 1'b0,
                       verdict: '{status: ST_CLEAN, byte_idx: '0, bit_pos: '0}};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ecc_byte_fixup u_fix (
        .verdict  (ctl_q.verdict),
        .idx      (fix_idx),
        .byte_in  (fix_byte_in),
        .byte_out (fix_byte_out)
    );

    assign in_ready   = ctl_q.ready;
    assign out_valid  = ctl_q.pulse;
    assign out_status = ctl_q.verdict.status;
    assign out_chunk  = ctl_q.chunk;
    assign fail_byte  = ctl_q.verdict.byte_idx;
    assign fail_bit   = ctl_q.verdict.bit_pos;

    // Verdict pulse follows each handshake by one cycle
    assert_pulse_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    assert_no_spurious_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);
    assert_result_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> ($stable(out_status) && $stable(fail_byte)
                                     && $stable(fail_bit) && $stable(out_chunk)));
    // Location fields only carry meaning for a corrected verdict
    assert_location_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_status != 2'd1) |-> (fail_byte == '0 && fail_bit == '0));
    // Fix-up flips at most one bit, and none unless corrected
    assert_fix_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fix_byte_out ^ fix_byte_in) <= 1);
    assert_fix_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_status != 2'd1) |-> (fix_byte_out == fix_byte_in));
    // Narrow pages always report chunk zero
    assert_narrow_chunk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !wide_page) |=> (out_chunk == 1'b0));
    // Two wide-page handshakes in a row land in opposite chunks
    assert_wide_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && wide_page && out_valid && $past(wide_page))
            |=> (out_chunk != $past(out_chunk)));
endmodule

// File: tb/sim_ecc_chunk_check.sv
`timescale 1ns/1ps
module sim_ecc_chunk_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        wide_page = 1'b0;
    logic [23:0] calc_code = '0;
    logic [23:0] stored_code = '0;
    logic        out_valid;
    logic [1:0]  out_status;
    logic        out_chunk;
    logic [7:0]  fail_byte;
    logic [2:0]  fail_bit;
    logic [7:0]  fix_idx = '0;
    logic [7:0]  fix_byte_in = '0;
    logic [7:0]  fix_byte_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit exp_next_chunk = 1'b0;

    always #2.5 clk = ~clk;

    ecc_chunk_check u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .wide_page(wide_page), .calc_code(calc_code), .stored_code(stored_code),
        .out_valid(out_valid), .out_status(out_status), .out_chunk(out_chunk),
        .fail_byte(fail_byte), .fail_bit(fail_bit), .fix_idx(fix_idx),
        .fix_byte_in(fix_byte_in), .fix_byte_out(fix_byte_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Reference verdict {status[1:0], byte[7:0], bit[2:0]} built from R2..R5, R9
    function automatic logic [12:0] ref_verdict(input logic [23:0] c, input logic [23:0] s);
        logic [23:0] syn;
        logic [10:0] mix;
        int n;
        syn = c ^ s;
        n = 0;
        for (int i = 0; i < 24; i++) n += int'(syn[i]);
        mix = (c[10:0] ^ c[21:11]) ^ (s[10:0] ^ s[21:11]);
        if (syn == 0 || c == 0 || s == 0) return {2'd0, 11'd0};
        if (n == 1) return {2'd2, 11'd0};
        if (n == 11 && mix == 11'h7FF) return {2'd1, syn[10:3], syn[2:0]};
        return {2'd3, 11'd0};
    endfunction

    task automatic run_pair(input logic [23:0] c, input logic [23:0] s, input bit wide,
                            input string tag);
        logic [12:0] e;
        bit exp_chunk;
        logic [7:0] probe;
        e = ref_verdict(c, s);
        exp_chunk = wide ? exp_next_chunk : 1'b0;
        exp_next_chunk = wide ? ~exp_next_chunk : 1'b0;
        @(negedge clk);
        calc_code = c; stored_code = s; wide_page = wide; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R6 pulse", int'(out_valid), 1);
        check(out_status == e[12:11], tag, int'(out_status), int'(e[12:11]));
        check({fail_byte, fail_bit} == e[10:0], tag, int'({fail_byte, fail_bit}), int'(e[10:0]));
        check(out_chunk == exp_chunk, "R8 chunk", int'(out_chunk), int'(exp_chunk));
        // R7 fix-up at the failing index and at another index
        probe = 8'($urandom);
        fix_byte_in = probe; fix_idx = e[10:3];
        #0.5;
        if (e[12:11] == 2'd1)
            check(fix_byte_out == (probe ^ (8'd1 << e[2:0])), "R7 flip",
                  int'(fix_byte_out), int'(probe ^ (8'd1 << e[2:0])));
        else
            check(fix_byte_out == probe, "R3/R7 unchanged", int'(fix_byte_out), int'(probe));
        fix_idx = e[10:3] ^ 8'h5A;
        #0.5;
        check(fix_byte_out == probe, "R7 other index", int'(fix_byte_out), int'(probe));
        @(negedge clk);
        check(out_valid == 1'b0, "R6 single pulse", int'(out_valid), 0);
        check(out_status == e[12:11], "R6 hold", int'(out_status), int'(e[12:11]));
    endtask

    function automatic logic [23:0] single_err_syn(input logic [7:0] b, input logic [2:0] t);
        logic [10:0] p;
        p = {b, t};
        return {2'b00, ~p, p};
    endfunction

    function automatic logic [23:0] nonzero_code();
        logic [23:0] v;
        v = 24'($urandom) | 24'h000100;
        return v;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] s;
        void'($urandom(32'h00C0FFEE));
        #1;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b0, "R1 in_ready in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // Directed corners
        s = 24'h3A5C71;
        run_pair(s, s, 1'b0, "R2 equal codes");
        run_pair(24'h0, s, 1'b0, "R2 calc zero");
        run_pair(s, 24'h0, 1'b0, "R2 stored zero");
        run_pair(s ^ 24'h800000, s, 1'b0, "R3 top bit flipped");
        run_pair(s ^ 24'h000010, s, 1'b0, "R3 low bit flipped");
        run_pair(s ^ single_err_syn(8'd0, 3'd0), s, 1'b0, "R4 byte0 bit0");
        run_pair(s ^ single_err_syn(8'd255, 3'd7), s, 1'b0, "R4 byte255 bit7");
        run_pair(s ^ 24'h0013FF, s, 1'b0, "R5 unsplit pair");
        run_pair(s ^ 24'h000003, s, 1'b0, "R5 two bits");
        // R8 page sequencing
        run_pair(s, s, 1'b1, "R8 wide first");
        run_pair(s ^ single_err_syn(8'd17, 3'd4), s, 1'b1, "R8 wide second");
        run_pair(s, s, 1'b0, "R8 narrow restart");
        run_pair(s ^ 24'h000001, s, 1'b1, "R8 wide after narrow");

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            logic [23:0] st;
            logic [23:0] ca;
            int kind;
            st = nonzero_code();
            kind = int'($urandom % 5);
            case (kind)
                0: ca = st;
                1: ca = st ^ (24'd1 << ($urandom % 24));
                2: ca = st ^ single_err_syn(8'($urandom), 3'($urandom));
                3: ca = 24'($urandom);
                default: ca = 24'h0;
            endcase
            run_pair(ca, st, 1'($urandom), "R2-R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule